// File: doc/BRIEF.md
# Reseeding Stochastic Number Generator

This block turns a fixed-point fraction into a unipolar stochastic bit stream. A conversion begins when the start input rises. From then on a maximal-length linear feedback shift register produces one pseudo-random word per clock. Each word is compared with the fraction, and the comparison result is the stream bit for that clock. The stream runs for exactly one register period, 2^WIDTH - 1 clocks, so the fraction is coded as the number of ones divided by that period.

The register is loaded from a stored seed at the start of every conversion. When a conversion finishes, the stored seed is stepped by one. Two conversions of the same fraction therefore produce the same count of ones in a different order. This small perturbation keeps a chaotic iteration built on the stream from settling into a short cycle.

The fraction is captured when the conversion starts. While a conversion is in progress, further start edges are ignored. The stream is meant to feed downstream stochastic logic such as AND or multiplexer elements. Decoding the stream is left to the consumer.

Top module: `reseed_sng`

## Requirements
- R1: A conversion starts only on a rising edge of `start`, when `start` is 1 in a cycle after being 0 in the previous one. Holding `start` at 1 never starts a further conversion.
- R2: During a conversion, `stream_bit` is 1 exactly when the current register word, taken as an unsigned number, is less than or equal to the captured fraction. While `stream_valid` is 0, `stream_bit` is 0.
- R3: The register word sequence begins with the stored seed. Each next word is the current word shifted one place toward the MSB, with a new LSB equal to the XOR of the tap bits. For WIDTH 16 the taps are bits 15, 14, 12 and 3. For WIDTH 4 they are bits 3 and 2.
- R4: A conversion of fraction v produces exactly v ones, for v from 0 up to 2^WIDTH - 1.
- R5: `stream_valid` goes high in the cycle after the accepted start edge. It then stays high for exactly 2^WIDTH - 1 consecutive cycles.
- R6: `done` is a one-cycle pulse. It appears in the cycle right after the last valid stream cycle.
- R7: After each conversion, the stored seed is incremented by one. The next conversion starts from the new seed.
- R8: If a seed value, either an increment result or `seed_init` at reset, would be zero, the value 1 is used instead.
- R9: Start edges that arrive during a conversion are ignored. Changes of `value` during a conversion do not alter the stream.
- R10: While `rst_n` is low, `stream_valid`, `stream_bit` and `done` are 0, and the stored seed is taken from `seed_init`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | A rising edge requests a conversion |
| value | input | WIDTH | Unsigned fraction, captured at the start of a conversion |
| seed_init | input | WIDTH | Seed loaded during reset |
| stream_bit | output | 1 | Stochastic stream bit |
| stream_valid | output | 1 | High during the cycles of a conversion |
| done | output | 1 | One-cycle pulse after the final stream bit |

## Verification
The hardest case to reach from the ports is the seed wrap. Incrementing past the all-ones seed would give the lockup word zero, so the block must skip to 1. At the default width this would take tens of thousands of conversions. The bench therefore builds a 4-bit instance, resets it with a seed two steps below all ones, and runs a table of conversions across the wrap. For each conversion it compares the stream, one bit per cycle, against its own register model started from the expected seed. A directed run raises a second start edge and changes `value` in the middle of a conversion. It then holds `start` high after completion, which checks the ignore rule and the edge-only start together. A single full run of the 16-bit instance then checks the real taps and the period.

// File: rtl/srg_pkg.sv
package srg_pkg;

   localparam int unsigned SRG_MIN_W = 3;
   localparam int unsigned SRG_MAX_W = 16;

   // Feedback tap mask of a maximal-length register, bit i set = tap on bit i.
   function automatic logic [SRG_MAX_W-1:0] srg_taps(input int unsigned w);
      logic [SRG_MAX_W-1:0] m;
      m = '0;
      case (w)
         3:  begin m[2] = 1'b1; m[1] = 1'b1; end
         4:  begin m[3] = 1'b1; m[2] = 1'b1; end
         5:  begin m[4] = 1'b1; m[2] = 1'b1; end
         6:  begin m[5] = 1'b1; m[4] = 1'b1; end
         7:  begin m[6] = 1'b1; m[5] = 1'b1; end
         8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
         9:  begin m[8] = 1'b1; m[4] = 1'b1; end
         10: begin m[9] = 1'b1; m[6] = 1'b1; end
         11: begin m[10] = 1'b1; m[8] = 1'b1; end
         12: begin m[11] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
         13: begin m[12] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
         14: begin m[13] = 1'b1; m[4] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
         15: begin m[14] = 1'b1; m[13] = 1'b1; end
         default: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/srg_edge.sv
module srg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/srg_lfsr.sv
module srg_lfsr
   import srg_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             advance,
   output logic [WIDTH-1:0] word
);
   localparam logic [SRG_MAX_W-1:0] FULL_MASK = srg_taps(WIDTH);
   localparam logic [WIDTH-1:0]     TAP_MASK  = FULL_MASK[WIDTH-1:0];

   // Running XOR over the tapped bits, one stage per bit position.
   logic [WIDTH:0] chain;
   assign chain[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (TAP_MASK[i]) begin : g_on
         assign chain[i+1] = chain[i] ^ word[i];
      end else begin : g_off
         assign chain[i+1] = chain[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       word <= '0;
      else if (load)    word <= load_val;
      else if (advance) word <= {word[WIDTH-2:0], chain[WIDTH]};
   end
endmodule

// File: rtl/srg_seed.sv
module srg_seed #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] seed_init,
   input  logic             bump,
   output logic [WIDTH-1:0] seed
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] init_safe;
   logic [WIDTH-1:0] plus_one;
   logic [WIDTH-1:0] bump_safe;

   assign init_safe = (seed_init == '0) ? ONE : seed_init;
   assign plus_one  = seed + ONE;
   assign bump_safe = (plus_one == '0) ? ONE : plus_one;

   always_ff @(posedge clk) begin
      if (!rst_n)    seed <= init_safe;
      else if (bump) seed <= bump_safe;
   end
endmodule

// File: rtl/srg_ctrl.sv
module srg_ctrl #(
   parameter int unsigned WIDTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   output logic launch,
   output logic busy,
   output logic finish,
   output logic done
);
   localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}} - 1'b1;

   logic [WIDTH-1:0] cnt;

   assign launch = rise & ~busy;
   assign finish = busy & (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (launch) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (finish) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (busy) begin
            cnt  <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/reseed_sng.sv
module reseed_sng
   import srg_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] value,
   input  logic [WIDTH-1:0] seed_init,
   output logic             stream_bit,
   output logic             stream_valid,
   output logic             done
);
   if (WIDTH < SRG_MIN_W || WIDTH > SRG_MAX_W) begin : g_bad_width
      $error("reseed_sng: WIDTH must lie between 3 and 16");
   end

   logic             rise;
   logic             launch;
   logic             busy;
   logic             finish;
   logic [WIDTH-1:0] seed;
   logic [WIDTH-1:0] lfsr_q;
   logic [WIDTH-1:0] frac_q;

   srg_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (start),
      .rise  (rise)
   );

   srg_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .launch (launch),
      .busy   (busy),
      .finish (finish),
      .done   (done)
   );

   srg_seed #(.WIDTH(WIDTH)) u_seed (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_init (seed_init),
      .bump      (finish),
      .seed      (seed)
   );

   srg_lfsr #(.WIDTH(WIDTH)) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .load_val (seed),
      .advance  (busy),
      .word     (lfsr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      frac_q <= '0;
      else if (launch) frac_q <= value;
   end

   assign stream_valid = busy;
   assign stream_bit   = busy & (lfsr_q <= frac_q);
endmodule

// File: rtl/reseed_sng_chk.sv
module reseed_sng_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stream_bit,
   input logic             stream_valid,
   input logic             done,
   input logic [WIDTH-1:0] lfsr_q
);
   localparam logic [WIDTH:0] PERIOD = {1'b0, {WIDTH{1'b1}}};

   logic [WIDTH:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)            run_len <= '0;
      else if (stream_valid) run_len <= run_len + 1'b1;
      else                   run_len <= '0;
   end

   p_bit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stream_valid |-> !stream_bit);

   p_valid_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stream_valid) |-> run_len == PERIOD);

   p_done_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stream_valid) |-> done);

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stream_valid) |-> $past(start));

   p_word_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stream_valid |-> lfsr_q != '0);

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |=> !stream_valid && !done);
endmodule

bind reseed_sng reseed_sng_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .stream_bit   (stream_bit),
   .stream_valid (stream_valid),
   .done         (done),
   .lfsr_q       (lfsr_q)
);

// File: tb/reseed_sng_bench.sv
`timescale 1ns/1ps
module reseed_sng_bench;
   localparam int SW = 4;
   localparam int SP = 15;
   localparam int LW = 16;
   localparam int LP = 65535;
   localparam int NV = 6;
   // {fraction, expected seed} per table row; seeds cross the all-ones wrap.
   localparam int TV [NV] = '{0, 15, 7, 1, 14, 8};
   localparam int TS [NV] = '{13, 14, 15, 1, 2, 3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_start = 1'b0;
   logic [SW-1:0] s_value = '0;
   logic [SW-1:0] s_seed = 4'd13;
   logic s_bit, s_valid, s_done;
   logic l_start = 1'b0;
   logic [LW-1:0] l_value = '0;
   logic [LW-1:0] l_seed = 16'hACE1;
   logic l_bit, l_valid, l_done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   reseed_sng #(.WIDTH(SW)) u_reseed_sng (
      .clk(clk), .rst_n(rst_n), .start(s_start), .value(s_value),
      .seed_init(s_seed), .stream_bit(s_bit), .stream_valid(s_valid),
      .done(s_done));

   reseed_sng #(.WIDTH(LW)) u_reseed_sng_w16 (
      .clk(clk), .rst_n(rst_n), .start(l_start), .value(l_value),
      .seed_init(l_seed), .stream_bit(l_bit), .stream_valid(l_valid),
      .done(l_done));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int step4(input int w);
      return ((w << 1) & 4'hF) | (((w >> 3) ^ (w >> 2)) & 1);
   endfunction

   function automatic int step16(input int w);
      return ((w << 1) & 16'hFFFF) |
             (((w >> 15) ^ (w >> 14) ^ (w >> 12) ^ (w >> 3)) & 1);
   endfunction

   // Run one 4-bit conversion; poke adds a mid-run start edge and value change.
   task automatic run4(input int v, input int s, input bit poke);
      int ones = 0, vcnt = 0, mism = 0, dmid = 0, w = s;
      @(negedge clk); s_value = SW'(v); s_start = 1'b1;
      @(negedge clk);
      for (int k = 0; k < SP; k++) begin
         if (s_valid) vcnt++;
         if (s_bit) ones++;
         if (s_done) dmid++;
         if (s_bit != (w <= v)) mism++;
         w = step4(w);
         if (!poke && k == 0) s_start = 1'b0;
         if (poke && k == 2) begin s_start = 1'b0; s_value = 4'd2; end
         if (poke && k == 5) s_start = 1'b1;
         @(negedge clk);
      end
      check(mism == 0, poke ? "R9 stream unchanged" : "R2 R3 R7 stream vs model", mism, 0);
      check(ones == v, "R4 ones count", ones, v);
      check(vcnt == SP && !s_valid, "R5 valid length", vcnt, SP);
      check(s_done && dmid == 0, "R6 done after last bit", s_done, 1);
      @(negedge clk);
      check(!s_done, "R6 done single pulse", s_done, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            check(1'b0, "watchdog", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!s_valid && !s_bit && !s_done, "R10 reset outputs",
            {s_valid, s_bit, s_done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!s_valid, "R1 idle without edge", s_valid, 0);

      for (int i = 0; i < NV; i++) run4(TV[i], TS[i], 1'b0);

      // R9 ignored edge; R1 start held high after completion must not restart.
      run4(9, 4, 1'b1);
      begin
         int seen = 0;
         for (int k = 0; k < 6; k++) begin
            if (s_valid) seen++;
            @(negedge clk);
         end
         check(seen == 0, "R1 level held no restart", seen, 0);
      end
      s_start = 1'b0;
      run4(5, 5, 1'b0);  // R7 seed advanced once only

      // R8 zero seed at reset becomes 1.
      rst_n = 1'b0; s_seed = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run4(6, 1, 1'b0);

      // Full-width conversion with the 16-bit taps.
      begin
         int ones = 0, vcnt = 0, mism = 0, w = 16'hACE1, v = 16'h1234;
         @(negedge clk); l_value = 16'h1234; l_start = 1'b1;
         @(negedge clk); l_start = 1'b0;
         for (int k = 0; k < LP; k++) begin
            if (l_valid) vcnt++;
            if (l_bit) ones++;
            if (l_bit != (w <= v)) mism++;
            w = step16(w);
            @(negedge clk);
         end
         check(mism == 0, "R3 16-bit stream vs model", mism, 0);
         check(ones == v, "R4 16-bit ones count", ones, v);
         check(vcnt == LP && !l_valid, "R5 16-bit valid length", vcnt, LP);
         check(l_done, "R6 16-bit done", l_done, 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule